// File: doc/BRIEF.md
# Power-Supply Fault Protection Sequencer

This block is the supervisor that sits between the digitized supply and fault comparators of a switching power controller and its gate driver. It watches synchronous flags that report where the supply rail sits relative to its start, stop and clear thresholds. It also watches for supply over-voltage, a feedback level held high by overload, die over-temperature, and an external shutdown request. From these flags it decides whether the PWM gate may switch and whether the high-voltage start-up current source should be charging the supply capacitor. It also reports the fault that currently holds the gate off.

A build-time parameter selects between two variants. In the auto-recovery variant each fault has its own release condition. An overload is cleared on the second supply collapse after the trip. An over-voltage is cleared at the next start crossing, which gives hiccup operation. An over-temperature is cleared when the temperature flag, which carries the comparator's hysteresis, falls. In the latch-off variant every fault holds until the supply drops below the clear level. The external shutdown request behaves as a latch in both variants, and it is ignored for a verification window just after start-up. All durations are clock-count parameters.

Top module: `psu_guard`

## Requirements
- R1: Operation starts on a cycle where `vcc_on`=1 and `vcc_uv`=0 and stops on a cycle where `vcc_uv`=1; one clock later `hv_en` is 0 while operating and 1 otherwise, and `gate_en` is 1 only while operating with no fault held.
- R2: An overload trips only after `fb_ovl` has been sampled high on more than OLP_DLY consecutive cycles while operating (exactly OLP_DLY samples do not trip, OLP_DLY+1 do); the trip turns the gate off.
- R3: Any cycle with `fb_ovl`=0 restarts the overload count from zero.
- R4: In auto-recovery mode (LATCH_MODE=0) a held overload is released on the second stop event (operating to `vcc_uv`=1) after the trip; the first stop event leaves it held.
- R5: In latch-off mode (LATCH_MODE=1) a held overload, over-voltage or over-temperature is released only by a cycle with `vcc_dl`=1; stopping and restarting without it leaves the fault held.
- R6: In auto-recovery mode an over-voltage (`vcc_ov`=1 while operating) holds the gate off until the next start crossing; a stop alone does not release it.
- R7: In auto-recovery mode an over-temperature (`hot`=1 while operating) holds the gate off until a cycle with `hot`=0.
- R8: An external request (`ext_req`=1 while operating and past the verification window) holds the gate off in both modes until a cycle with `vcc_dl`=1.
- R9: `ext_req` is ignored during the first VERIFY_CYC cycles of operation.
- R10: `fault_code` is 0 for no fault, 1 overload, 2 over-voltage, 3 over-temperature, 4 external request; when several faults are held the highest of 4, 3, 2, 1 is shown, and the gate is off whenever the code is not 0.
- R11: After reset `gate_en`=0, `hv_en`=1 and `fault_code`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vcc_on | input | 1 | Supply above the start threshold |
| vcc_uv | input | 1 | Supply below the stop threshold |
| vcc_dl | input | 1 | Supply below the fault-clear level |
| vcc_ov | input | 1 | Supply above the over-voltage level |
| fb_ovl | input | 1 | Feedback at or above the overload level |
| hot | input | 1 | Die over-temperature, hysteresis applied upstream |
| ext_req | input | 1 | External shutdown request |
| gate_en | output | 1 | PWM gate may switch |
| hv_en | output | 1 | High-voltage start-up source enable |
| fault_code | output | 3 | Held fault with the highest priority |

## Verification
The two functions that can land on the same clock are the setting of several protection latches and the priority encoding of the status code: an over-temperature and an over-voltage, or an external request together with both, can be raised on one cycle. The bench raises those flags on the same edge, in both variants, and judges that the code shows the highest-priority fault. After the flags are withdrawn, it checks that each lower fault either remains or is released according to its own rule. A second coincidence, an overload count expiring as the supply collapses, is kept apart by holding the feedback flag low around each stop event.

// File: rtl/psu_guard_pkg.sv
package psu_guard_pkg;

  typedef enum logic [2:0] {
    FC_NONE = 3'd0,
    FC_OVL  = 3'd1,
    FC_OVV  = 3'd2,
    FC_HOT  = 3'd3,
    FC_EXT  = 3'd4
  } fault_e;

  localparam int NFAULT = 4;
  localparam int IDX_OVL = 0;
  localparam int IDX_OVV = 1;
  localparam int IDX_HOT = 2;
  localparam int IDX_EXT = 3;

  function automatic fault_e encode_fault(input logic [NFAULT-1:0] held);
    if (held[IDX_EXT])      return FC_EXT;
    else if (held[IDX_HOT]) return FC_HOT;
    else if (held[IDX_OVV]) return FC_OVV;
    else if (held[IDX_OVL]) return FC_OVL;
    else                    return FC_NONE;
  endfunction

endpackage

// File: rtl/psu_guard_dwell.sv
// Counts consecutive cycles of a level, saturating at LIMIT.
module psu_guard_dwell #(
  parameter int LIMIT = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic level,
  output logic reached
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !level) cnt <= '0;
    else if (cnt != W'(LIMIT)) cnt <= cnt + 1'b1;
  end

  assign reached = (cnt == W'(LIMIT));
endmodule

// File: rtl/psu_guard_trip.sv
// One protection latch: set has priority over release.
module psu_guard_trip (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic rel,
  output logic q,
  output logic nxt
);
  always_comb begin
    if (set)      nxt = 1'b1;
    else if (rel) nxt = 1'b0;
    else          nxt = q;
  end

  always_ff @(posedge clk) begin
    if (rst) q <= 1'b0;
    else     q <= nxt;
  end
endmodule

// File: rtl/psu_guard.sv
module psu_guard
  import psu_guard_pkg::*;
#(
  parameter bit LATCH_MODE = 1'b0,
  parameter int OLP_DLY    = 2_250_000,
  parameter int VERIFY_CYC = 12_500_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       vcc_on,
  input  logic       vcc_uv,
  input  logic       vcc_dl,
  input  logic       vcc_ov,
  input  logic       fb_ovl,
  input  logic       hot,
  input  logic       ext_req,
  output logic       gate_en,
  output logic       hv_en,
  output logic [2:0] fault_code
);

  logic run_q, run_n, run_rise, run_fall;
  logic ovl_reached, win_done, ovl_expire;
  logic [NFAULT-1:0] set_v, rel_v, held_q, held_n;

  // supply sequencing with hysteresis between start and stop levels
  always_comb begin
    if (run_q) run_n = !vcc_uv;
    else       run_n = vcc_on && !vcc_uv;
  end
  assign run_rise = !run_q && run_n;
  assign run_fall = run_q && !run_n;

  always_ff @(posedge clk) begin
    if (rst) run_q <= 1'b0;
    else     run_q <= run_n;
  end

  psu_guard_dwell #(.LIMIT(OLP_DLY)) u_ovl_timer (
    .clk(clk), .rst(rst), .level(run_q && fb_ovl), .reached(ovl_reached)
  );

  psu_guard_dwell #(.LIMIT(VERIFY_CYC)) u_verify_win (
    .clk(clk), .rst(rst), .level(run_q), .reached(win_done)
  );

  assign ovl_expire = run_q && fb_ovl && ovl_reached;

  assign set_v[IDX_OVL] = ovl_expire;
  assign set_v[IDX_OVV] = run_q && vcc_ov;
  assign set_v[IDX_HOT] = run_q && hot;
  assign set_v[IDX_EXT] = run_q && win_done && ext_req;
  assign rel_v[IDX_EXT] = vcc_dl;

  generate
    if (LATCH_MODE) begin : g_latch
      assign rel_v[IDX_OVL] = vcc_dl;
      assign rel_v[IDX_OVV] = vcc_dl;
      assign rel_v[IDX_HOT] = vcc_dl;
    end else begin : g_auto
      logic half_q;
      always_ff @(posedge clk) begin
        if (rst || set_v[IDX_OVL])          half_q <= 1'b0;
        else if (held_q[IDX_OVL] && run_fall) half_q <= ~half_q;
      end
      assign rel_v[IDX_OVL] = held_q[IDX_OVL] && half_q && run_fall;
      assign rel_v[IDX_OVV] = run_rise;
      assign rel_v[IDX_HOT] = !hot;
    end
  endgenerate

  for (genvar i = 0; i < NFAULT; i++) begin : g_trip
    psu_guard_trip u_trip (
      .clk(clk), .rst(rst), .set(set_v[i]), .rel(rel_v[i]),
      .q(held_q[i]), .nxt(held_n[i])
    );
  end

  // registered outputs taken from next state
  always_ff @(posedge clk) begin
    if (rst) begin
      gate_en    <= 1'b0;
      hv_en      <= 1'b1;
      fault_code <= FC_NONE;
    end else begin
      gate_en    <= run_n && (held_n == '0);
      hv_en      <= !run_n;
      fault_code <= encode_fault(held_n);
    end
  end

endmodule

// File: rtl/psu_guard_chk.sv
module psu_guard_chk #(
  parameter int OLP_DLY = 8
) (
  input logic       clk,
  input logic       rst,
  input logic       vcc_on,
  input logic       vcc_uv,
  input logic       vcc_dl,
  input logic       fb_ovl,
  input logic       gate_en,
  input logic       hv_en,
  input logic [2:0] fault_code
);
  localparam int HW = $clog2(OLP_DLY + 2);
  localparam logic [HW-1:0] HMAX = HW'(OLP_DLY + 1);

  logic [HW-1:0] hcnt;
  always_ff @(posedge clk) begin
    if (rst || !fb_ovl) hcnt <= '0;
    else if (hcnt != HMAX) hcnt <= hcnt + 1'b1;
  end

  p_hv_run_r1: assert property (@(posedge clk) disable iff (rst)
    (vcc_on && !vcc_uv) |=> !hv_en);

  p_uv_stop_r1: assert property (@(posedge clk) disable iff (rst)
    vcc_uv |=> (!gate_en && hv_en));

  p_gate_hv_r1: assert property (@(posedge clk) disable iff (rst)
    !(gate_en && hv_en));

  p_ovl_wait_r2: assert property (@(posedge clk) disable iff (rst)
    (fault_code == 3'd1 && $past(fault_code) == 3'd0) |-> (hcnt == HMAX));

  p_ext_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fault_code == 3'd4) |=> (fault_code == 3'd4 || $past(vcc_dl)));

  p_code_gate_r10: assert property (@(posedge clk) disable iff (rst)
    (fault_code != 3'd0) |-> !gate_en);

  p_code_range_r10: assert property (@(posedge clk) disable iff (rst)
    fault_code <= 3'd4);
endmodule

bind psu_guard psu_guard_chk #(.OLP_DLY(OLP_DLY)) u_chk (
  .clk(clk), .rst(rst), .vcc_on(vcc_on), .vcc_uv(vcc_uv), .vcc_dl(vcc_dl),
  .fb_ovl(fb_ovl), .gate_en(gate_en), .hv_en(hv_en), .fault_code(fault_code)
);

// File: tb/psu_guard_test.sv
`timescale 1ns/1ps
module psu_guard_test;
  localparam int OLP = 8;
  localparam int VER = 6;

  logic clk = 1'b0;
  logic rst;
  logic vcc_on, vcc_uv, vcc_dl, vcc_ov, fb_ovl, hot, ext_req;
  logic gate_en, hv_en, gate_l, hv_l;
  logic [2:0] fault_code, code_l;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  psu_guard #(.LATCH_MODE(1'b0), .OLP_DLY(OLP), .VERIFY_CYC(VER)) uut (
    .clk(clk), .rst(rst), .vcc_on(vcc_on), .vcc_uv(vcc_uv), .vcc_dl(vcc_dl),
    .vcc_ov(vcc_ov), .fb_ovl(fb_ovl), .hot(hot), .ext_req(ext_req),
    .gate_en(gate_en), .hv_en(hv_en), .fault_code(fault_code));

  psu_guard #(.LATCH_MODE(1'b1), .OLP_DLY(OLP), .VERIFY_CYC(VER)) uut_lat (
    .clk(clk), .rst(rst), .vcc_on(vcc_on), .vcc_uv(vcc_uv), .vcc_dl(vcc_dl),
    .vcc_ov(vcc_ov), .fb_ovl(fb_ovl), .hot(hot), .ext_req(ext_req),
    .gate_en(gate_l), .hv_en(hv_l), .fault_code(code_l));

  // flags {ext,hot,fb,ov,dl,uv,on}, cycles, then expected {gate,hv,code} of auto unit
  localparam int NV = 22;
  localparam logic [15:0] TBL [NV] = '{
    {7'b0000000, 4'd3, 1'b0, 1'b1, 3'd0},  // R1 idle
    {7'b0000001, 4'd3, 1'b1, 1'b0, 3'd0},  // R1 start
    {7'b0000000, 4'd3, 1'b1, 1'b0, 3'd0},  // R1 hysteresis
    {7'b0010000, 4'd5, 1'b1, 1'b0, 3'd0},  // R3 short overload
    {7'b0000000, 4'd2, 1'b1, 1'b0, 3'd0},  // R3 gap
    {7'b0010000, 4'd5, 1'b1, 1'b0, 3'd0},  // R3 count restarted
    {7'b0010000, 4'd5, 1'b0, 1'b0, 3'd1},  // R2 trip
    {7'b0000000, 4'd3, 1'b0, 1'b0, 3'd1},  // R4 held
    {7'b0000010, 4'd3, 1'b0, 1'b1, 3'd1},  // R4 first stop
    {7'b0000001, 4'd3, 1'b0, 1'b0, 3'd1},  // R4 restart, still held
    {7'b0000010, 4'd3, 1'b0, 1'b1, 3'd0},  // R4 second stop releases
    {7'b0000001, 4'd3, 1'b1, 1'b0, 3'd0},  // R4 switching again
    {7'b0001001, 4'd3, 1'b0, 1'b0, 3'd2},  // R6 over-voltage
    {7'b0000000, 4'd3, 1'b0, 1'b0, 3'd2},  // R6 held
    {7'b0000010, 4'd3, 1'b0, 1'b1, 3'd2},  // R6 stop keeps it
    {7'b0000001, 4'd3, 1'b1, 1'b0, 3'd0},  // R6 start releases
    {7'b0100000, 4'd3, 1'b0, 1'b0, 3'd3},  // R7 hot
    {7'b0000000, 4'd3, 1'b1, 1'b0, 3'd0},  // R7 cooled
    {7'b0101000, 4'd3, 1'b0, 1'b0, 3'd3},  // R10 hot over over-voltage
    {7'b0000000, 4'd3, 1'b0, 1'b0, 3'd2},  // R10 over-voltage shows
    {7'b0000010, 4'd3, 1'b0, 1'b1, 3'd2},  // R6 stop
    {7'b0000001, 4'd3, 1'b1, 1'b0, 3'd0}   // R6 start
  };

  task automatic drive(input logic [6:0] f);
    {ext_req, hot, fb_ovl, vcc_ov, vcc_dl, vcc_uv, vcc_on} = f;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got gate=%0b hv=%0b code=%0d, expected gate=%0b hv=%0b code=%0d",
               tag, act[4], act[3], act[2:0], exp[4], exp[3], exp[2:0]);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    drive(7'b0);
    wait_cyc(3);
    rst = 1'b0;
  endtask

  function automatic logic [4:0] a_out();
    return {gate_en, hv_en, fault_code};
  endfunction

  function automatic logic [4:0] l_out();
    return {gate_l, hv_l, code_l};
  endfunction

  initial begin
    rst = 1'b1;
    drive(7'b0);
    wait_cyc(3);
    check("R11 reset auto", a_out(), 5'b01000);
    check("R11 reset latch", l_out(), 5'b01000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      drive(TBL[i][15:9]);
      wait_cyc(int'(TBL[i][8:5]));
      check($sformatf("vector %0d", i), a_out(), TBL[i][4:0]);
    end

    // R2 boundary: OLP samples do not trip, OLP+1 do
    do_reset();
    check("R11 reset again", a_out(), 5'b01000);
    drive(7'b0000001); wait_cyc(3);
    drive(7'b0010001); wait_cyc(OLP);
    drive(7'b0000001);
    check("R2 exact delay no trip", a_out(), 5'b10000);
    wait_cyc(1);
    check("R3 no late trip", a_out(), 5'b10000);
    drive(7'b0010001); wait_cyc(OLP + 1);
    check("R2 trip auto", a_out(), 5'b00001);
    check("R2 trip latch", l_out(), 5'b00001);

    // R4 vs R5 overload release
    drive(7'b0000010); wait_cyc(3);
    drive(7'b0000001); wait_cyc(3);
    drive(7'b0000010); wait_cyc(3);
    drive(7'b0000001); wait_cyc(3);
    check("R4 auto released", a_out(), 5'b10000);
    check("R5 latch overload held", l_out(), 5'b00001);
    drive(7'b0000110); wait_cyc(3);
    check("R5 latch overload cleared", l_out(), 5'b01000);
    drive(7'b0000001); wait_cyc(3);
    check("R5 latch switching", l_out(), 5'b10000);

    // R5 over-voltage in latch mode
    drive(7'b0001001); wait_cyc(3);
    check("R5 ovv latch trip", l_out(), 5'b00010);
    drive(7'b0000010); wait_cyc(3);
    drive(7'b0000001); wait_cyc(3);
    check("R6 ovv auto hiccup release", a_out(), 5'b10000);
    check("R5 ovv latch held", l_out(), 5'b00010);
    drive(7'b0000110); wait_cyc(3);
    drive(7'b0000001); wait_cyc(3);
    check("R5 ovv latch cleared", l_out(), 5'b10000);

    // R5 over-temperature in latch mode
    drive(7'b0100001); wait_cyc(3);
    check("R7 hot auto", a_out(), 5'b00011);
    drive(7'b0000001); wait_cyc(3);
    check("R7 cool auto", a_out(), 5'b10000);
    check("R5 hot latch held", l_out(), 5'b00011);
    drive(7'b0000010); wait_cyc(3);
    drive(7'b0000001); wait_cyc(3);
    check("R5 hot latch recycle held", l_out(), 5'b00011);
    drive(7'b0000110); wait_cyc(3);
    drive(7'b0000001); wait_cyc(3);
    check("R5 hot latch cleared", l_out(), 5'b10000);

    // R9 verification window, R8 external latch
    do_reset();
    drive(7'b1000001); wait_cyc(4);
    check("R9 ext ignored auto", a_out(), 5'b10000);
    check("R9 ext ignored latch", l_out(), 5'b10000);
    wait_cyc(6);
    check("R8 ext auto", a_out(), 5'b00100);
    check("R8 ext latch", l_out(), 5'b00100);
    drive(7'b0000010); wait_cyc(3);
    drive(7'b0000001); wait_cyc(3);
    check("R8 recycle keeps auto", a_out(), 5'b00100);
    check("R8 recycle keeps latch", l_out(), 5'b00100);
    drive(7'b0000110); wait_cyc(3);
    check("R8 clear level releases", a_out(), 5'b01000);
    drive(7'b0000001); wait_cyc(3);
    check("R8 switching after clear", a_out(), 5'b10000);

    // R10 coincident faults past the window
    wait_cyc(10);
    drive(7'b1101001); wait_cyc(2);
    check("R10 ext wins auto", a_out(), 5'b00100);
    check("R10 ext wins latch", l_out(), 5'b00100);
    drive(7'b0000001); wait_cyc(3);
    check("R10 ext still shown auto", a_out(), 5'b00100);
    check("R10 ext still shown latch", l_out(), 5'b00100);
    drive(7'b0000110); wait_cyc(3);
    drive(7'b0000001); wait_cyc(3);
    check("R10 all released auto", a_out(), 5'b10000);
    check("R10 all released latch", l_out(), 5'b10000);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got running, expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule